// File: doc/BRIEF.md
# Auto-Incrementing Indirect RAM Port

This block holds a 128-byte RAM that a host reaches only through two windows on an 8-bit synchronous CPU bus with a 16-bit address. One window is a pointer register. A write there sets the RAM address and a sticky step flag. The other window is a data port. A write to it stores a byte at the pointer. A read from it returns the byte at the pointer on the read data output one clock after the strobe.

When the step flag is set, every data-port access moves the pointer on by one. This covers reads, writes, and a cycle that strobes both. The pointer is 7 bits wide, so it wraps from 0x7F to 0x00. A host can therefore fill or dump a run of bytes with one pointer write followed by a string of data accesses. Anything that uses the stored bytes sits outside this block.

Top module: `ind_ram_port`

## Requirements
- R1: After a clock with rst_n low, the read data output is 0x00, the pointer is 0, the step flag is clear, and every RAM byte is 0x00.
- R2: A write strobe with an address from 0xF800 to 0xFFFF loads the pointer from data bits 6:0 and the step flag from data bit 7. The new values apply to the next access.
- R3: A write strobe with an address from 0x4800 to 0x4FFF stores the data byte at the RAM location the pointer holds.
- R4: A read strobe with an address from 0x4800 to 0x4FFF places the byte at the pointer, taken before any step, on the read data output one clock later. The output keeps that value until the next read strobe.
- R5: With the step flag set, each clock that carries a data-port read or write strobe advances the pointer by exactly one.
- R6: A step from pointer 0x7F gives pointer 0x00.
- R7: With the step flag clear, data-port accesses leave the pointer unchanged.
- R8: A clock with both strobes at the data port returns the old byte, stores the new byte in the same location, and steps the pointer at most once.
- R9: Strobes at addresses outside both windows change neither the RAM nor the pointer. A read strobe outside the data window gives 0x00 on the read data output one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
A read and a write can land on the data port in the same clock. They then share one pointer value and one step. The bench produces this by raising both strobes with the step flag set. It places the location just before the wrap so that the step also crosses 0x7F. The behavioural model expects the old byte on the output, the new byte stored, and a single step. Later step-mode reads confirm all three, both at the affected location and after it.

// File: rtl/ind_ram_pkg.sv
// Package: shared types and default window bounds for the indirect RAM port.
// Assumes: windows are inclusive address ranges on a 16-bit bus.
package ind_ram_pkg;
    localparam logic [15:0] DATA_WIN_LO = 16'h4800;
    localparam logic [15:0] DATA_WIN_HI = 16'h4FFF;
    localparam logic [15:0] PTR_WIN_LO  = 16'hF800;
    localparam logic [15:0] PTR_WIN_HI  = 16'hFFFF;

    // Decoded per-cycle bus command.
    typedef struct packed {
        logic data_rd;   // read strobe inside data window
        logic data_wr;   // write strobe inside data window
        logic ptr_ld;    // write strobe inside pointer window
        logic any_rd;    // any read strobe
    } irp_cmd_t;

    // Inclusive range test used by the decoder.
    function automatic logic in_range(input logic [15:0] a,
                                      input logic [15:0] lo,
                                      input logic [15:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction
endpackage

// File: rtl/irp_decode.sv
// Module: bus decoder. Turns address and strobes into a command struct.
// Assumes: strobes last one clock; purely combinational.
module irp_decode
    import ind_ram_pkg::*;
#(
    parameter logic [15:0] D_LO = DATA_WIN_LO,
    parameter logic [15:0] D_HI = DATA_WIN_HI,
    parameter logic [15:0] P_LO = PTR_WIN_LO,
    parameter logic [15:0] P_HI = PTR_WIN_HI
) (
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    output irp_cmd_t    cmd
);
    logic hit_data;
    logic hit_ptr;

    // Window match and strobe qualification.
    always_comb begin
        hit_data    = in_range(addr, D_LO, D_HI);
        hit_ptr     = in_range(addr, P_LO, P_HI);
        cmd.data_rd = rd && hit_data;
        cmd.data_wr = wr && hit_data;
        cmd.ptr_ld  = wr && hit_ptr;
        cmd.any_rd  = rd;
    end
endmodule

// File: rtl/irp_pointer.sv
// Module: RAM pointer with sticky step flag.
// Assumes: load and data access never coincide (distinct windows, one address).
module irp_pointer
    import ind_ram_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irp_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              step_en
);
    logic access;

    // One step per clock with any data-port strobe.
    always_comb access = cmd.data_rd || cmd.data_wr;

    // Pointer and flag register: load, step with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            step_en <= 1'b0;
        end else if (cmd.ptr_ld) begin
            ptr     <= wdata[ADDR_W-1:0];
            step_en <= wdata[DATA_W-1];
        end else if (access && step_en) begin
            ptr     <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/irp_store.sv
// Module: byte array with registered read port, read-before-write.
// Assumes: one write and one read per clock at the same pointer.
module irp_store
    import ind_ram_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irp_cmd_t          cmd,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // One register per byte, cleared on reset, written when selected.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[i] <= '0;
            else if (cmd.data_wr && (ptr == ADDR_W'(i)))
                cells[i] <= wdata;
        end
    end

    // Read register: captures old byte on a data read, zero elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (cmd.any_rd)
            rdata <= cmd.data_rd ? cells[ptr] : '0;
    end
endmodule

// File: rtl/ind_ram_port.sv
// Module: top of the indirect RAM port. Wires decoder, pointer and store.
// Assumes: synchronous bus, ADDR_W < DATA_W so the flag bit is separate.
module ind_ram_port
    import ind_ram_pkg::*;
#(
    parameter int          ADDR_W = 7,
    parameter int          DATA_W = 8,
    parameter logic [15:0] D_LO   = DATA_WIN_LO,
    parameter logic [15:0] D_HI   = DATA_WIN_HI,
    parameter logic [15:0] P_LO   = PTR_WIN_LO,
    parameter logic [15:0] P_HI   = PTR_WIN_HI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    irp_cmd_t          cmd;
    logic [ADDR_W-1:0] ptr_q;
    logic              inc_q;

    irp_decode #(.D_LO(D_LO), .D_HI(D_HI), .P_LO(P_LO), .P_HI(P_HI)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .cmd  (cmd)
    );

    irp_pointer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .wdata   (bus_wdata),
        .ptr     (ptr_q),
        .step_en (inc_q)
    );

    irp_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ptr   (ptr_q),
        .wdata (bus_wdata),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/irp_checker.sv
// Module: temporal checks on the indirect RAM port, bound to its top.
// Assumes: same parameters as the top; observes ports and pointer state.
module irp_checker #(
    parameter int          ADDR_W = 7,
    parameter int          DATA_W = 8,
    parameter logic [15:0] D_LO   = 16'h4800,
    parameter logic [15:0] D_HI   = 16'h4FFF,
    parameter logic [15:0] P_LO   = 16'hF800,
    parameter logic [15:0] P_HI   = 16'hFFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [ADDR_W-1:0] ptr,
    input logic              inc
);
    logic              in_d;
    logic              in_p;
    logic              acc;
    logic [ADDR_W-1:0] ptr_plus;

    // Independent window view and expected step value.
    always_comb begin
        in_d     = (bus_addr >= D_LO) && (bus_addr <= D_HI);
        in_p     = (bus_addr >= P_LO) && (bus_addr <= P_HI);
        acc      = (bus_rd || bus_wr) && in_d;
        ptr_plus = ptr + 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0 && !inc && bus_rdata == '0)); // R1
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_p) |=> (ptr == $past(bus_wdata[ADDR_W-1:0]) && inc == $past(bus_wdata[DATA_W-1]))); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && inc) |=> (ptr == $past(ptr_plus))); // R5
    AST_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !inc) |=> $stable(ptr)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !(bus_wr && in_p)) |=> ($stable(ptr) && $stable(inc))); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R4
    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_d) |=> (bus_rdata == '0)); // R9
endmodule

bind ind_ram_port irp_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .D_LO(D_LO), .D_HI(D_HI), .P_LO(P_LO), .P_HI(P_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ptr       (ptr_q),
    .inc       (inc_q)
);

// File: tb/ind_ram_port_test.sv
`timescale 1ns/1ps
// Bench: behavioural model of RAM, pointer and read register, compared every clock.
module ind_ram_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;

    int  m_mem [128];
    int  m_ptr, m_inc, m_rd;
    int  n_cmp = 0, n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    ind_ram_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    function automatic bit in_data(int a);
        return a >= 'h4800 && a <= 'h4FFF;
    endfunction
    function automatic bit in_ptr(int a);
        return a >= 'hF800 && a <= 'hFFFF;
    endfunction

    // Compare read data against the model, away from the edge.
    task automatic compare(string tag);
        n_cmp++;
        if (bus_rdata !== m_rd[7:0]) begin
            n_bad++;
            $display("FAIL %s: rdata actual=%02h expected=%02h", tag, bus_rdata, m_rd[7:0]);
        end
    endtask

    // Drive one clock of bus activity, advance the model, then compare.
    task automatic cyc(int a, int d, bit r, bit w, string tag);
        int old;
        bus_addr = a[15:0]; bus_wdata = d[7:0]; bus_rd = r; bus_wr = w;
        @(posedge clk);
        old = m_mem[m_ptr];
        if (r) m_rd = in_data(a) ? old : 0;
        if (w && in_data(a)) m_mem[m_ptr] = d & 'hFF;
        if (w && in_ptr(a)) begin
            m_ptr = d & 'h7F; m_inc = (d >> 7) & 1;
        end else if ((r || w) && in_data(a) && m_inc != 0) begin
            m_ptr = (m_ptr + 1) % 128;
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (2) @(posedge clk);
        foreach (m_mem[i]) m_mem[i] = 0;
        m_ptr = 0; m_inc = 0; m_rd = 0;
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: dump all bytes after reset with stepping on
        cyc('hF800, 'h80, 0, 1, "R2");
        for (int i = 0; i < 128; i++) cyc('h4800, 0, 1, 0, "R1");
        // R3 R5: fill a run with stepping
        cyc('hFFFF, 'h90, 0, 1, "R2");
        for (int i = 0; i < 6; i++) cyc('h4FFF, 'hA0 + i, 0, 1, "R3");
        cyc('hF900, 'h90, 0, 1, "R2");
        for (int i = 0; i < 6; i++) cyc('h4800, 0, 1, 0, "R5");
        // R7: no stepping, repeated read and overwrite at one location
        cyc('hFC00, 'h12, 0, 1, "R2");
        for (int i = 0; i < 3; i++) cyc('h4A00, 0, 1, 0, "R7");
        cyc('h4A00, 'h5C, 0, 1, "R7");
        cyc('h4A00, 0, 1, 0, "R7");
        cyc('hFC00, 'h93, 0, 1, "R2");
        cyc('h4800, 0, 1, 0, "R7");
        // R6: write across the wrap and read it back
        cyc('hF800, 'hFE, 0, 1, "R2");
        for (int i = 0; i < 4; i++) cyc('h4800, 'h60 + i, 0, 1, "R6");
        cyc('hF800, 'hFE, 0, 1, "R2");
        for (int i = 0; i < 4; i++) cyc('h4800, 0, 1, 0, "R6");
        // R8: both strobes together at 0x7F, then check old, new and single step
        cyc('hF800, 'hFF, 0, 1, "R2");
        cyc('h4800, 'hC3, 1, 1, "R8");
        cyc('h4800, 0, 1, 0, "R8");
        cyc('hF800, 'hFF, 0, 1, "R2");
        cyc('h4800, 0, 1, 0, "R8");
        cyc('h4800, 0, 1, 0, "R8");
        // R9: accesses just outside the windows
        cyc('hF800, 'h85, 0, 1, "R2");
        cyc('h47FF, 'h11, 0, 1, "R9");
        cyc('h5000, 'h22, 0, 1, "R9");
        cyc('hF7FF, 'h33, 0, 1, "R9");
        cyc('h4800, 0, 1, 0, "R4");
        cyc('h5000, 0, 1, 0, "R9");
        cyc('hF800, 0, 1, 0, "R9");
        cyc('h4800, 0, 1, 0, "R9");
        // R4: output holds through idle clocks and non-read writes
        cyc('h0000, 0, 0, 0, "R4");
        cyc('h4800, 'h77, 0, 1, "R4");
        cyc('h0000, 0, 0, 0, "R4");
        // R1: reset mid-run clears written bytes
        do_reset();
        cyc('hF800, 'h90, 0, 1, "R2");
        for (int i = 0; i < 4; i++) cyc('h4800, 0, 1, 0, "R1");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule